// File: doc/BRIEF.md
# Dual-Clock FIFO with Full and Partial Reset

This block is a first-in first-out buffer for 36-bit words that lets a producer and a consumer run on separate clocks. The clocks may be unrelated or may be the same clock. The storage depth is a parameter, chosen as 256, 512 or 1024 words. The write side reports full and almost-full. The read side reports empty and almost-empty. The two "almost" flags share one offset, and that offset can be a fixed value or programmed at run time.

The block has two reset inputs with different reach. A full reset empties the buffer and also chooses how the flag offset is set up:

- a fixed offset of 8, 16 or 64, or
- a programmable offset, loaded either in one step from the write data bus or shifted in one bit per write clock.

A partial reset only empties the buffer. It leaves the chosen set-up method and the current offset value untouched, so a stream can be restarted without programming the offset again.

Top module: `xfifo_dual_clk`

## Requirements
- R1: While either reset input is high, the flags read empty=1, almostEmpty=1, full=0 and almostFull=0. After a full reset, rdData reads 0.
- R2: Words leave in the order they were written. On a rising rdClk edge where rdEn=1 and empty=0, rdData takes the oldest word, and it is valid right after that edge.
- R3: full goes high on the write edge that stores word number DEPTH. A write attempted while full is high is dropped and does not disturb the stored words.
- R4: A read attempted while empty is high is ignored: rdData holds its value and the read position does not move.
- R5: almostFull is high when the free space, as seen from the write side, is at most the offset. It updates on the write edge itself.
- R6: almostEmpty is high when the occupancy, as seen from the read side, is at most the offset. It updates on the read edge itself.
- R7: While fullRst is high, the cfgSel input is captured with this encoding: 0 gives a fixed offset of 8, 1 gives 16, 2 gives 64, 3 selects serial programming, 4 selects parallel programming, and 5 to 7 act as 0. Both programmable modes start with an offset of 8.
- R8: In parallel mode, a write-clock edge with offLoad=1 loads wrData[AW-1:0] into the offset, where AW=log2(DEPTH). In any other mode, offLoad has no effect.
- R9: In serial mode, each write-clock edge with serEn=1 shifts serIn into the offset least significant bit, so the value enters most significant bit first. In any other mode, serEn has no effect.
- R10: A partial reset empties the FIFO, so reading restarts at the next word written, and it keeps both the programming mode and the offset value.
- R11: Writes presented while either reset input is high are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| fullRst | input | 1 | Full reset, active high: clears the pointers and captures the offset set-up |
| partRst | input | 1 | Partial reset, active high: clears the pointers only |
| cfgSel | input | 3 | Offset set-up code, sampled during full reset |
| wrEn | input | 1 | Write enable |
| wrData | input | WIDTH | Write data; the low AW bits also carry a parallel offset |
| offLoad | input | 1 | Parallel offset load strobe |
| serEn | input | 1 | Serial offset shift enable |
| serIn | input | 1 | Serial offset data bit |
| rdEn | input | 1 | Read enable |
| rdData | output | WIDTH | Registered read data |
| full | output | 1 | FIFO full (write side) |
| almostFull | output | 1 | Free space at or below the offset (write side) |
| empty | output | 1 | FIFO empty (read side) |
| almostEmpty | output | 1 | Occupancy at or below the offset (read side) |

## Verification
The properties rely on the following conditions:

- Each reset input is held for several edges of both clocks.
- cfgSel stays stable while fullRst is high and for a few write clocks after it falls.
- The offset is programmed only while no words are moving. This matters because the read side uses the offset without a synchroniser.
- offLoad is never combined with a write.

The stimulus respects all of these. It programs offsets only right after a full reset. It waits a few cycles of both clocks before switching between a burst of writes and a burst of reads, so the flag thresholds can be checked on exact cycles of the side that owns each flag.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  typedef enum logic [2:0] {
    CFG_DEF8     = 3'd0,
    CFG_DEF16    = 3'd1,
    CFG_DEF64    = 3'd2,
    CFG_SERIAL   = 3'd3,
    CFG_PARALLEL = 3'd4
  } cfgMode_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrDo;
    logic rdDo;
    logic rdClr;
  } memStrobe_t;

  function automatic int defaultOffset(cfgMode_e m);
    case (m)
      CFG_DEF16: return 16;
      CFG_DEF64: return 64;
      default:   return 8;
    endcase
  endfunction

endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync (
  input  logic clk,
  input  logic rstIn,
  output logic rstOut
);
  logic [1:0] stage;

  // Asserts at once, releases after two clean edges of clk
  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) stage <= 2'b11;
    else       stage <= {stage[0], 1'b0};
  end

  assign rstOut = stage[1];
endmodule

// File: rtl/xfifo_ctrl.sv
module xfifo_ctrl
  import xfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             fullRst,
  input  logic             partRst,
  input  logic [2:0]       cfgSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             offLoad,
  input  logic             serEn,
  input  logic             serIn,
  input  logic [AW-1:0]    wrDataLow,
  output memStrobe_t       stb,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output logic             full,
  output logic             almostFull,
  output logic             empty,
  output logic             almostEmpty,
  output logic [AW:0]      wrLevel,
  output logic [AW-1:0]    offset
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- reset synchronisers ----------------
  logic anyRst, wrRst, rdRst, wrCfgRst;
  assign anyRst = fullRst | partRst;

  xfifo_rst_sync u_wrRst  (.clk(wrClk), .rstIn(anyRst),  .rstOut(wrRst));
  xfifo_rst_sync u_rdRst  (.clk(rdClk), .rstIn(anyRst),  .rstOut(rdRst));
  xfifo_rst_sync u_cfgRst (.clk(wrClk), .rstIn(fullRst), .rstOut(wrCfgRst));

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, rdGrayW1, rdGrayW2, rdBinW, freeW;
  logic [PW-1:0] rdBin, rdGray;
  logic          fullInt, wrDo;

  assign rdBinW  = fromGray(rdGrayW2);
  assign wrLevel = wrBin - rdBinW;
  assign freeW   = DEPTH_P - wrLevel;
  assign fullInt = (wrLevel == DEPTH_P);
  assign wrDo    = wrEn && !fullInt && !wrRst;

  always_ff @(posedge wrClk or posedge wrRst) begin
    if (wrRst) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayW1 <= '0;
      rdGrayW2 <= '0;
    end else begin
      rdGrayW1 <= rdGray;
      rdGrayW2 <= rdGrayW1;
      if (wrDo) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end
    end
  end

  assign full       = fullInt && !wrRst;
  assign almostFull = (freeW <= {1'b0, offset}) && !wrRst;

  // ---------------- read domain ----------------
  logic [PW-1:0] wrGrayR1, wrGrayR2, wrBinR, rdLevel;
  logic          emptyInt, rdDo;

  assign wrBinR   = fromGray(wrGrayR2);
  assign rdLevel  = wrBinR - rdBin;
  assign emptyInt = (rdLevel == '0);
  assign rdDo     = rdEn && !emptyInt && !rdRst;

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayR1 <= '0;
      wrGrayR2 <= '0;
    end else begin
      wrGrayR1 <= wrGray;
      wrGrayR2 <= wrGrayR1;
      if (rdDo) begin
        rdBin  <= rdBin + 1'b1;
        rdGray <= toGray(rdBin + 1'b1);
      end
    end
  end

  assign empty       = emptyInt || rdRst;
  assign almostEmpty = (rdLevel <= {1'b0, offset}) || rdRst;

  // ---------------- offset configuration ----------------
  cfgMode_e mode, modeSel;

  always_comb begin
    case (cfgSel)
      3'd1:    modeSel = CFG_DEF16;
      3'd2:    modeSel = CFG_DEF64;
      3'd3:    modeSel = CFG_SERIAL;
      3'd4:    modeSel = CFG_PARALLEL;
      default: modeSel = CFG_DEF8;
    endcase
  end

  always_ff @(posedge wrClk) begin
    if (wrCfgRst) begin
      mode   <= modeSel;
      offset <= AW'(defaultOffset(modeSel));
    end else if (!wrRst) begin
      if (mode == CFG_PARALLEL && offLoad)
        offset <= wrDataLow;
      else if (mode == CFG_SERIAL && serEn)
        offset <= {offset[AW-2:0], serIn};
    end
  end

  // ---------------- datapath strobes ----------------
  always_comb begin
    stb.wrDo  = wrDo;
    stb.rdDo  = rdDo;
    stb.rdClr = rdRst;
  end

  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = rdBin[AW-1:0];
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem
  import xfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  memStrobe_t       stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrDo) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (stb.rdClr)     rdData <= '0;
    else if (stb.rdDo) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/xfifo_dual_clk.sv
module xfifo_dual_clk
  import xfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             fullRst,
  input  logic             partRst,
  input  logic [2:0]       cfgSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             offLoad,
  input  logic             serEn,
  input  logic             serIn,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             almostFull,
  output logic             empty,
  output logic             almostEmpty
);
  localparam int AW = $clog2(DEPTH);

  memStrobe_t    stb;
  logic [AW-1:0] wrAddr, rdAddr, offset;
  logic [AW:0]   wrLevel;

  xfifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .fullRst(fullRst), .partRst(partRst),
    .cfgSel(cfgSel), .wrEn(wrEn), .rdEn(rdEn), .offLoad(offLoad),
    .serEn(serEn), .serIn(serIn), .wrDataLow(wrData[AW-1:0]),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .full(full), .almostFull(almostFull), .empty(empty),
    .almostEmpty(almostEmpty), .wrLevel(wrLevel), .offset(offset)
  );

  xfifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
    .wrClk(wrClk), .rdClk(rdClk), .stb(stb), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/xfifo_checker.sv
module xfifo_checker #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             fullRst,
  input logic             partRst,
  input logic             wrEn,
  input logic             rdEn,
  input logic [WIDTH-1:0] rdData,
  input logic             full,
  input logic             almostFull,
  input logic             empty,
  input logic             almostEmpty,
  input logic [AW:0]      wrLevel,
  input logic [AW-1:0]    offset
);
  always @(posedge wrClk) begin
    if (fullRst || partRst)
      assert_rst_wr_flags_R1: assert (!full && !almostFull)
        else $error("write-side flags set during reset");
  end

  always @(posedge rdClk) begin
    if (fullRst || partRst)
      assert_rst_rd_flags_R1: assert (empty && almostEmpty)
        else $error("read-side flags clear during reset");
  end

  assert_no_overflow_R3: assert property (@(posedge wrClk)
    disable iff (fullRst || partRst) wrLevel <= (AW+1)'(DEPTH))
    else $error("occupancy above depth");

  assert_full_by_write_R3: assert property (@(posedge wrClk)
    disable iff (fullRst || partRst) $rose(full) |-> $past(wrEn))
    else $error("full rose without a write");

  assert_empty_by_read_R2: assert property (@(posedge rdClk)
    disable iff (fullRst || partRst) $rose(empty) |-> $past(rdEn))
    else $error("empty rose without a read");

  assert_hold_data_R4: assert property (@(posedge rdClk)
    disable iff (fullRst || partRst) (!rdEn || empty) |=> $stable(rdData))
    else $error("read data moved without a read");

  assert_full_af_R5: assert property (@(posedge wrClk)
    disable iff (fullRst || partRst) full |-> almostFull)
    else $error("full without almost-full");

  assert_empty_ae_R6: assert property (@(posedge rdClk)
    disable iff (fullRst || partRst) empty |-> almostEmpty)
    else $error("empty without almost-empty");

  assert_keep_offset_R10: assert property (@(posedge wrClk)
    disable iff (fullRst) partRst |=> $stable(offset))
    else $error("offset changed across partial reset");
endmodule

bind xfifo_dual_clk xfifo_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_chk (.*);

// File: tb/sim_xfifo_dual_clk.sv
module sim_xfifo_dual_clk;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD + 4;
  localparam int DEPTH = 256;
  localparam int WIDTH = 36;

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic fullRst = 1'b1, partRst = 1'b0;
  logic [2:0] cfgSel = 3'd0;
  logic wrEn = 1'b0, offLoad = 1'b0, serEn = 1'b0, serIn = 1'b0, rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic full, almostFull, empty, almostEmpty;

  int tests = 0, fails = 0, cnt = 0;
  int seqNo = 0;
  logic [WIDTH-1:0] expQ[$];
  event rdDone;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2)  rdClk = ~rdClk;

  xfifo_dual_clk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .fullRst(fullRst), .partRst(partRst),
    .cfgSel(cfgSel), .wrEn(wrEn), .wrData(wrData), .offLoad(offLoad),
    .serEn(serEn), .serIn(serIn), .rdEn(rdEn), .rdData(rdData),
    .full(full), .almostFull(almostFull), .empty(empty), .almostEmpty(almostEmpty)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Monitor: pops the scoreboard once per completed read
  initial begin
    forever begin
      logic [WIDTH-1:0] e;
      @(rdDone);
      e = expQ.pop_front();
      chk("R2 data order", 64'(rdData), 64'(e));
    end
  end

  task automatic settle();
    repeat (4) @(negedge wrClk);
    repeat (4) @(negedge rdClk);
  endtask

  task automatic doFullReset(input logic [2:0] sel);
    @(negedge wrClk);
    fullRst = 1'b1; cfgSel = sel;
    wrEn = 1'b0; rdEn = 1'b0; offLoad = 1'b0; serEn = 1'b0;
    repeat (4) @(negedge rdClk);
    chk("R1 full in reset", 64'(full), 0);
    chk("R1 almostFull in reset", 64'(almostFull), 0);
    chk("R1 empty in reset", 64'(empty), 1);
    chk("R1 almostEmpty in reset", 64'(almostEmpty), 1);
    chk("R1 rdData cleared", 64'(rdData), 0);
    @(negedge wrClk);
    fullRst = 1'b0;
    settle();
    expQ.delete();
    cnt = 0;
  endtask

  // Driver: one write, scoreboard entry only if the model has room
  task automatic pushWord();
    logic [WIDTH-1:0] d;
    seqNo++;
    d = {seqNo[17:0] ^ 18'h2A5A5, seqNo[17:0]};
    @(negedge wrClk);
    wrEn = 1'b1; wrData = d;
    @(negedge wrClk);
    wrEn = 1'b0;
    if (cnt < DEPTH) begin
      expQ.push_back(d);
      cnt++;
    end
  endtask

  task automatic pushTo(input int n);
    while (cnt < n) pushWord();
  endtask

  task automatic popWord();
    @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
    if (cnt > 0) begin
      cnt--;
      ->rdDone;
      #1;
    end
  endtask

  task automatic popTo(input int n);
    while (cnt > n) popWord();
  endtask

  // Fill up to the almost-full edge for offset off and check both sides of it
  task automatic afEdge(input int off, input string req);
    pushTo(DEPTH - off - 1);
    chk(req, 64'(almostFull), 0);
    pushWord();
    chk(req, 64'(almostFull), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // ---- fixed offset 8 ----
    doFullReset(3'd0);
    afEdge(8, "R5 almostFull at offset 8");
    pushTo(DEPTH - 1);
    chk("R3 not full at DEPTH-1", 64'(full), 0);
    pushWord();
    chk("R3 full at DEPTH", 64'(full), 1);
    pushWord();  // dropped
    chk("R3 still full after overflow attempt", 64'(full), 1);
    settle();
    popTo(9);
    chk("R6 almostEmpty off at 9", 64'(almostEmpty), 0);
    popWord();
    chk("R6 almostEmpty on at 8", 64'(almostEmpty), 1);
    popTo(0);
    chk("R2 empty after draining", 64'(empty), 1);
    begin
      logic [WIDTH-1:0] last;
      last = rdData;
      @(negedge rdClk); rdEn = 1'b1;
      @(negedge rdClk); rdEn = 1'b0;
      chk("R4 rdData held on empty read", 64'(rdData), 64'(last));
      chk("R4 still empty", 64'(empty), 1);
    end
    settle();
    pushWord(); pushWord();
    settle();
    popTo(0);  // monitor checks the read position was not moved

    // ---- fixed offset 64; programming strobes ignored ----
    doFullReset(3'd2);
    @(negedge wrClk); offLoad = 1'b1; wrData = 36'd5;
    @(negedge wrClk); offLoad = 1'b0;
    for (int b = 0; b < 8; b++) begin
      @(negedge wrClk); serEn = 1'b1; serIn = 1'b1;
    end
    @(negedge wrClk); serEn = 1'b0;
    afEdge(64, "R7 R8 R9 offset 64 kept");

    // ---- partial reset keeps offset 64; writes blocked ----
    @(negedge wrClk);
    partRst = 1'b1; wrEn = 1'b1; wrData = 36'h123;
    repeat (4) @(negedge rdClk);
    chk("R1 empty in partial reset", 64'(empty), 1);
    chk("R1 full clear in partial reset", 64'(full), 0);
    @(negedge wrClk);
    partRst = 1'b0; wrEn = 1'b0;
    settle();
    chk("R11 R10 empty after partial reset", 64'(empty), 1);
    expQ.delete(); cnt = 0;
    afEdge(64, "R10 offset kept after partial reset");
    settle();
    popTo(cnt - 3);

    // ---- parallel mode ----
    doFullReset(3'd4);
    @(negedge wrClk); offLoad = 1'b1; wrData = 36'd20;
    @(negedge wrClk); offLoad = 1'b0;
    afEdge(20, "R8 parallel offset 20");
    settle();
    popTo(21);
    chk("R6 almostEmpty off at 21", 64'(almostEmpty), 0);
    popWord();
    chk("R6 almostEmpty on at 20", 64'(almostEmpty), 1);

    // ---- serial mode: value 40 shifted MSB first ----
    doFullReset(3'd3);
    for (int b = 7; b >= 0; b--) begin
      @(negedge wrClk); serEn = 1'b1; serIn = 1'((8'd40 >> b) & 8'd1);
    end
    @(negedge wrClk); serEn = 1'b0;
    @(negedge wrClk); offLoad = 1'b1; wrData = 36'd3;
    @(negedge wrClk); offLoad = 1'b0;
    afEdge(40, "R9 serial offset 40");

    // ---- fixed offset 16 ----
    doFullReset(3'd1);
    afEdge(16, "R7 offset 16");

    // ---- unused code acts as offset 8 ----
    doFullReset(3'd6);
    afEdge(8, "R7 code 6 gives offset 8");

    settle();
    finishRun();
  end
endmodule